// File: doc/BRIEF.md
# Prescaled Multi-Mode Interval Timer

This block is a register-programmed interval timer. A programmable prescaler divides the input clock. Each prescaler period advances a 24-bit up counter, and the counter is compared against a programmed 24-bit compare value. The block has four operating modes, chosen by a 2-bit field: one-shot, periodic, toggle-output and free-running. When the counter reaches the compare value, a sticky match flag is set. Software clears the flag by writing a one to it. An interrupt line reports the flag when the interrupt enable is set.

Software reaches the timer through a single-cycle write port and a combinational read port. A soft-reset bit, a read-only active bit and an optional data mirror of the counter are part of the control interface. A debug-halt input freezes counting unless software has chosen to let the timer run through debug halts. In free-running mode the counter wraps modulo 2^24. Compare values 0 and 1 are outside the supported range.

Top module: `prog_timer`

## Requirements
- R1: After a synchronous active-low reset, all four registers read zero, and `irq` and `toggle_out` are low. The registers are control at address 0, compare at address 1, status at address 2 and data mirror at address 3.
- R2: While counting, the counter advances by one every (P+1) clocks, where P is control bits [7:0].
- R3: When an advance makes the counter equal the compare value (address 1, bits [23:0]), status bit 0 is set. Writing 1 to that bit clears it. Writing 0 leaves it unchanged. A match in the same cycle as the clear wins.
- R4: `irq` is high exactly while status bit 0 is 1 and control bit 11 (interrupt enable) is 1.
- R5: In mode 0 (one-shot, control bits [9:8]), a match returns the counter to zero and clears the enable, control bit 10.
- R6: In mode 1 (periodic) and mode 2 (toggle), a match returns the counter to zero and counting continues. In mode 2, each match also inverts `toggle_out`.
- R7: In mode 3 (free-running), a match does not return the counter to zero, and the counter keeps advancing past the compare value.
- R8: A write to the compare register restarts the counter and the prescaler from zero in modes 0, 1 and 2. In mode 3 the write leaves counting undisturbed.
- R9: Writing a control word with bit 14 set while the enable is 1 clears the prescaler, the counter and the enable. While the enable is 0, bit 14 has no effect. Bit 14 always reads 0.
- R10: While control bit 12 is 1, the data mirror (address 3) takes the counter value after every clock. While it is 0, the mirror holds its value.
- R11: Control bit 15 reads the active state, which is 1 while the enable is 1. Clearing the enable suspends counting, and the counter holds its value.
- R12: While `dbg_halt` is high and control bit 13 is 0, the prescaler and the counter are frozen. With bit 13 set to 1, `dbg_halt` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Combinational read data |
| dbg_halt | input | 1 | Debug halt request |
| toggle_out | output | 1 | Toggle-mode output |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge on which it is sampled. A prescaler advance, a match, a restart or a soft reset also changes the counter, the flag, the enable and the mirror at that same edge. `irq` follows one edge after the flag's cause, and `rd_data` reflects the new state combinationally. The bench keeps a behavioural model that steps on the same edge and compares `irq`, `toggle_out` and the addressed read word 2 ns after every rising edge. Inputs change only on falling edges. The directed checks count edges explicitly, for example 41 edges at prescale 3 give 10 advances, and they sample between edges.

// File: rtl/timer_pkg.sv
// Shared types and register layout for the prescaled interval timer.
// Assumes a 32-bit register word and a 2-bit register address.
package timer_pkg;
    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_TOGGLE   = 2'd2,
        MODE_FREE     = 2'd3
    } tmr_mode_t;

    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_CMP    = 1;
    localparam int ADDR_STAT   = 2;
    localparam int ADDR_MIRROR = 3;

    localparam int BIT_MODE_LO = 8;
    localparam int BIT_EN      = 10;
    localparam int BIT_IE      = 11;
    localparam int BIT_MIRROR  = 12;
    localparam int BIT_DBGRUN  = 13;
    localparam int BIT_SRST    = 14;
    localparam int BIT_ACTIVE  = 15;
endpackage

// File: rtl/timer_prescaler.sv
// Clock divider: emits one advance pulse every (limit+1) cycles while run is high.
// Assumes limit may change at any time; a count at or above the limit wraps.
module timer_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic             at_limit;

    // Detect the end of one prescale period.
    always_comb begin
        at_limit = (pre_q >= limit);
        tick     = run && at_limit;
    end

    // Divider count: cleared on restart, advanced while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            pre_q <= '0;
        else if (run)
            pre_q <= at_limit ? '0 : pre_q + 1'b1;
    end

    // R12
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(pre_q));
endmodule

// File: rtl/timer_counter.sv
// 24-bit up counter with compare, per-mode match action and toggle output.
// Assumes tick and clear come from the same clock domain; clear wins over tick.
module timer_counter
    import timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  tmr_mode_t        mode,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_next,
    output logic             match,
    output logic             oneshot_stop,
    output logic             toggle_q
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    // Next counter value, match and one-shot stop request.
    always_comb begin
        cnt_inc      = cnt_q + 1'b1;
        match        = tick && (cnt_inc == cmp);
        oneshot_stop = match && (mode == MODE_ONESHOT);
        if (clear)
            cnt_next = '0;
        else if (match && mode != MODE_FREE)
            cnt_next = '0;
        else if (tick)
            cnt_next = cnt_inc;
        else
            cnt_next = cnt_q;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_next;
    end

    // Toggle output flips on every match in toggle mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            toggle_q <= 1'b0;
        else if (match && mode == MODE_TOGGLE)
            toggle_q <= ~toggle_q;
    end

    assign cnt = cnt_q;

    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt_q));
    // R6
    toggle_only_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(match && mode == MODE_TOGGLE) |=> $stable(toggle_q));
    // R5
    match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode != MODE_FREE) |=> (cnt_q == '0));
endmodule

// File: rtl/timer_readmux.sv
// Combinational register read selection.
// Assumes all inputs are already zero-extended fields of the register word.
module timer_readmux #(
    parameter int AW    = 2,
    parameter int DW    = 32,
    parameter int CNT_W = 24
) (
    input  logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    ctrl_word,
    input  logic [CNT_W-1:0] cmp,
    input  logic             flag,
    input  logic [CNT_W-1:0] mirror,
    output logic [DW-1:0]    rd_data
);
    // Select the addressed register.
    always_comb begin
        case (rd_addr)
            2'd0:    rd_data = ctrl_word;
            2'd1:    rd_data = DW'(cmp);
            2'd2:    rd_data = DW'(flag);
            default: rd_data = DW'(mirror);
        endcase
    end
endmodule

// File: rtl/prog_timer.sv
// Prescaled interval timer top: register file, run gating and interrupt.
// Assumes one register write per cycle; compare values 0 and 1 are unsupported.
module prog_timer
    import timer_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 24,
    parameter int DW    = 32,
    parameter int AW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          dbg_halt,
    output logic          toggle_out,
    output logic          irq
);
    localparam int CTRL_PAD = DW - BIT_ACTIVE - 1;

    logic [PRE_W-1:0] prescale_q;
    tmr_mode_t        mode_q;
    logic             enable_q, irq_en_q, mirror_en_q, dbg_run_q;
    logic [CNT_W-1:0] cmp_q, mirror_q;
    logic             flag_q;

    logic             wr_ctrl, wr_cmp, wr_stat;
    logic             run, soft_rst, restart, tick;
    logic [CNT_W-1:0] cnt, cnt_next;
    logic             match, oneshot_stop;
    logic [DW-1:0]    ctrl_word;

    // Write decode, run gating and restart sources.
    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == AW'(ADDR_CTRL));
        wr_cmp   = wr_en && (wr_addr == AW'(ADDR_CMP));
        wr_stat  = wr_en && (wr_addr == AW'(ADDR_STAT));
        run      = enable_q && !(dbg_halt && !dbg_run_q);
        soft_rst = wr_ctrl && wr_data[BIT_SRST] && enable_q;
        restart  = soft_rst || (wr_cmp && mode_q != MODE_FREE);
    end

    timer_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(restart),
        .limit(prescale_q), .tick(tick)
    );

    timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clear(restart),
        .mode(mode_q), .cmp(cmp_q), .cnt(cnt), .cnt_next(cnt_next),
        .match(match), .oneshot_stop(oneshot_stop), .toggle_q(toggle_out)
    );

    // Control fields; a one-shot match or soft reset drops the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale_q  <= '0;
            mode_q      <= MODE_ONESHOT;
            enable_q    <= 1'b0;
            irq_en_q    <= 1'b0;
            mirror_en_q <= 1'b0;
            dbg_run_q   <= 1'b0;
        end else if (wr_ctrl) begin
            prescale_q  <= wr_data[PRE_W-1:0];
            mode_q      <= tmr_mode_t'(wr_data[BIT_MODE_LO +: 2]);
            enable_q    <= wr_data[BIT_EN] && !soft_rst;
            irq_en_q    <= wr_data[BIT_IE];
            mirror_en_q <= wr_data[BIT_MIRROR];
            dbg_run_q   <= wr_data[BIT_DBGRUN];
        end else if (oneshot_stop) begin
            enable_q    <= 1'b0;
        end
    end

    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (wr_cmp)
            cmp_q <= wr_data[CNT_W-1:0];
    end

    // Sticky match flag, cleared by writing one; a match wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (match)
            flag_q <= 1'b1;
        else if (wr_stat && wr_data[0])
            flag_q <= 1'b0;
    end

    // Data mirror follows the counter only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mirror_q <= '0;
        else if (mirror_en_q)
            mirror_q <= cnt_next;
    end

    // Assemble the control read word and the interrupt line.
    always_comb begin
        ctrl_word = {{CTRL_PAD{1'b0}}, enable_q, 1'b0, dbg_run_q, mirror_en_q,
                     irq_en_q, enable_q, mode_q, {(BIT_MODE_LO-PRE_W){1'b0}}, prescale_q};
        irq       = flag_q && irq_en_q;
    end

    timer_readmux #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_rd (
        .rd_addr(rd_addr), .ctrl_word(ctrl_word), .cmp(cmp_q),
        .flag(flag_q), .mirror(mirror_q), .rd_data(rd_data)
    );

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_stat && wr_data[0])) |=> flag_q);
    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode_q == MODE_ONESHOT && !wr_ctrl) |=> !enable_q);
    // R9
    srst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!enable_q && cnt == '0));
endmodule

// File: tb/test_prog_timer.sv
module test_prog_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        dbg_halt = 1'b0;
    logic        toggle_out, irq;

    int checks = 0, fails = 0;
    bit chk_on = 0;

    always #4 clk = ~clk;

    prog_timer i_prog_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dbg_halt(dbg_halt), .toggle_out(toggle_out), .irq(irq)
    );

    // Behavioural model state
    int m_pre, m_ps, m_mode, m_cnt, m_cmp, m_data;
    bit m_en, m_ie, m_mir, m_dbgrun, m_flag, m_tog;
    localparam int MASK = 24'hFFFFFF;

    function automatic logic [31:0] mread(input int a);
        case (a)
            0: return {16'b0, m_en, 1'b0, m_dbgrun, m_mir, m_ie, m_en, m_mode[1:0], m_ps[7:0]};
            1: return 32'(m_cmp);
            2: return 32'(m_flag);
            default: return 32'(m_data);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_ps = 0; m_mode = 0; m_cnt = 0; m_cmp = 0; m_data = 0;
            m_en = 0; m_ie = 0; m_mir = 0; m_dbgrun = 0; m_flag = 0; m_tog = 0;
        end else begin
            bit old_en, old_mir, run, tick, hit;
            int old_mode, nxt;
            old_en = m_en; old_mir = m_mir; old_mode = m_mode;
            run = m_en && !(dbg_halt && !m_dbgrun);
            tick = 0; hit = 0;
            if (run) begin
                if (m_pre >= m_ps) begin m_pre = 0; tick = 1; end
                else m_pre = m_pre + 1;
            end
            if (tick) begin
                nxt = (m_cnt + 1) & MASK;
                if (nxt == m_cmp) begin
                    hit = 1; m_flag = 1;
                    if (m_mode == 2) m_tog = !m_tog;
                    m_cnt = (m_mode == 3) ? nxt : 0;
                    if (m_mode == 0) m_en = 0;
                end else m_cnt = nxt;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_ps = wr_data[7:0]; m_mode = wr_data[9:8]; m_en = wr_data[10];
                        m_ie = wr_data[11]; m_mir = wr_data[12]; m_dbgrun = wr_data[13];
                        if (wr_data[14] && old_en) begin m_cnt = 0; m_pre = 0; m_en = 0; end
                    end
                    2'd1: begin
                        m_cmp = wr_data[23:0];
                        if (old_mode != 3) begin m_cnt = 0; m_pre = 0; end
                    end
                    2'd2: if (wr_data[0] && !hit) m_flag = 0;
                    default: ;
                endcase
            end
            if (old_mir) m_data = m_cnt;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (chk_on) begin
            check("R4 irq", {31'b0, irq}, {31'b0, m_flag && m_ie});
            check("R6 toggle_out", {31'b0, toggle_out}, {31'b0, m_tog});
            case (rd_addr)
                2'd0: check("R11 ctrl read", rd_data, mread(0));
                2'd1: check("R8 compare read", rd_data, mread(1));
                2'd2: check("R3 status read", rd_data, mread(2));
                default: check("R10 mirror read", rd_data, mread(3));
            endcase
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a[1:0];
        #1 v = rd_data;
    endtask

    function automatic logic [31:0] ctl(input int ps, input int mode, input bit en,
                                        input bit ie, input bit mir, input bit dr, input bit sr);
        return 32'(ps) | (32'(mode) << 8) | (32'(en) << 10) | (32'(ie) << 11)
             | (32'(mir) << 12) | (32'(dr) << 13) | (32'(sr) << 14);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, v1, v2;
        int toggles;
        logic prev;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; chk_on = 1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin rd(a, v); check("R1 reset reg", v, 32'h0); end
        check("R1 irq low", {31'b0, irq}, 32'h0);
        check("R1 toggle low", {31'b0, toggle_out}, 32'h0);

        // R2 prescale 3 in free-running mode
        wr(1, 100);
        wr(0, ctl(3, 3, 1, 0, 1, 0, 0));
        rd_addr = 2'd3;
        repeat (40) @(negedge clk);
        rd(3, v); check("R2 advance every P+1", v, 32'd10);

        // R8 / R7 compare write in free-running mode does not restart
        wr(1, 12);
        #1 check("R8 no restart in mode 3", {31'b0, rd_data >= 32'd10}, 32'd1);
        repeat (20) @(negedge clk);
        rd(3, v); check("R7 passes compare", {31'b0, v > 32'd12}, 32'd1);
        rd(2, v); check("R3 flag set on match", v, 32'd1);

        // R3 write-one-to-clear
        wr(2, 0); rd(2, v); check("R3 write 0 keeps flag", v, 32'd1);
        wr(2, 1); rd(2, v); check("R3 write 1 clears flag", v, 32'd0);

        // R11 suspend
        wr(0, ctl(3, 3, 0, 0, 1, 0, 0));
        rd(0, v); check("R11 active low", {31'b0, v[15]}, 32'd0);
        rd(3, v1); repeat (9) @(negedge clk); rd(3, v2);
        check("R11 count held", v2, v1);
        // R9 ignored while disabled
        wr(0, ctl(3, 3, 0, 0, 1, 0, 1));
        rd(3, v); check("R9 soft reset ignored when idle", v, v1);
        rd(0, v); check("R9 bit14 reads 0", {31'b0, v[14]}, 32'd0);

        // R9 soft reset while active
        wr(0, ctl(0, 3, 1, 0, 1, 0, 0));
        rd(0, v); check("R11 active high", {31'b0, v[15]}, 32'd1);
        rd_addr = 2'd3;
        repeat (10) @(negedge clk);
        wr(0, ctl(0, 3, 1, 0, 1, 0, 1));
        #1 check("R9 counter cleared", rd_data, 32'd0);
        rd(0, v); check("R9 enable cleared", {31'b0, v[10]}, 32'd0);

        // R6 toggle mode period 4
        wr(1, 4);
        wr(0, ctl(0, 2, 1, 1, 1, 0, 0));
        prev = toggle_out; toggles = 0;
        repeat (40) begin
            @(negedge clk);
            if (toggle_out !== prev) toggles++;
            prev = toggle_out;
        end
        check("R6 toggle count", 32'(toggles), 32'd10);
        check("R4 irq with enable", {31'b0, irq}, 32'd1);
        wr(0, ctl(0, 2, 1, 0, 1, 0, 0));
        #1 check("R4 irq masked", {31'b0, irq}, 32'd0);

        // R8 compare write restarts in toggle mode
        rd_addr = 2'd3;
        wr(1, 50);
        #1 check("R8 restart on compare write", rd_data, 32'd0);

        // R5 one-shot
        wr(0, ctl(0, 0, 0, 1, 1, 0, 0));
        wr(1, 6);
        wr(0, ctl(0, 0, 1, 1, 1, 0, 0));
        repeat (20) @(negedge clk);
        rd(0, v); check("R5 enable cleared", {31'b0, v[10]}, 32'd0);
        rd(3, v); check("R5 counter zero", v, 32'd0);
        rd(2, v); check("R3 one-shot flag", v, 32'd1);

        // R12 debug halt freeze and override
        dbg_halt = 1'b1;
        wr(0, ctl(0, 3, 1, 0, 1, 0, 0));
        rd(3, v1); repeat (9) @(negedge clk); rd(3, v2);
        check("R12 frozen in halt", v2, v1);
        wr(0, ctl(0, 3, 1, 0, 1, 1, 0));
        rd(3, v1); repeat (9) @(negedge clk); rd(3, v2);
        check("R12 runs with override", v2, v1 + 32'd10);
        dbg_halt = 1'b0;

        // R10 mirror hold and resume
        wr(0, ctl(0, 3, 1, 0, 0, 0, 0));
        rd(3, v1); repeat (9) @(negedge clk); rd(3, v2);
        check("R10 mirror holds", v2, v1);
        wr(0, ctl(0, 3, 1, 0, 1, 0, 0));
        repeat (2) @(negedge clk);
        rd(3, v); check("R10 mirror resumes", {31'b0, v != v1}, 32'd1);

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule